// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block is the fault supervisor of a synchronous step-down converter's digital control. On every switching cycle it watches whether the high-side switch was turned on and whether that on-time was cut short by the high-side current limit. Repeated limit hits mean a short or a heavy overload. After enough of them, the block turns both power switches off and asks for the soft-start node to be discharged. It then waits a fixed number of switching cycles before it lets the converter start again. The hit counting stays live while soft-start is ramping.

An over-temperature flag, which arrives with its hysteresis already applied, holds the converter off in the same way. The enable input does too. Whenever the converter leaves any off condition, the block issues a single-clock restart strobe so that the soft-start sequence begins again. The analog current sensing, the thermal sensing and the soft-start ramp itself are outside this block.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset with `en` low, `sw_off` and `ss_dump` are 1 and `ss_restart` is 0. Raising `en` with no fault drops `sw_off` and `ss_dump` in the same clock.
- R2: A current-limit event is the first clock with `ilim_hit` high within a switching cycle, where a cycle runs from one `cyc_tick` to the next. Further `ilim_hit` pulses in the same cycle are not counted.
- R3: The event counter is 3 bits wide. The eighth counted event sets `sw_off` and `ss_dump` to 1 at the clock edge that samples it. Seven events leave both outputs at 0.
- R4: A clean pulse is a cycle in which `hs_start` was seen and no event occurred; it is judged at the `cyc_tick` that closes the cycle. Three consecutive clean pulses clear the event counter.
- R5: A counted event clears the clean-pulse count. Fewer than three clean pulses between events therefore do not clear the event counter.
- R6: A cycle with no `hs_start` changes neither the event count nor the clean-pulse count.
- R7: Once tripped, the off state lasts exactly 1024 `cyc_tick` pulses and ends at the clock that samples the 1024th. `ilim_hit` has no effect during this period, and the counters restart from zero afterwards.
- R8: `ss_restart` goes high for exactly one clock, one clock after the off condition (`en` low, `ot_fault` high, or hiccup) is released.
- R9: While `ot_fault` is high, `sw_off` and `ss_dump` are 1 and both counters are cleared. When `ot_fault` falls, the restart strobe of R8 follows.
- R10: While `en` is low, `sw_off` is 1 and both counters and the hiccup timer are cleared. Lowering `en` during a hiccup ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| cyc_tick | input | 1 | One-clock strobe at the start of each switching cycle |
| hs_start | input | 1 | One-clock strobe when the high-side switch turns on |
| ilim_hit | input | 1 | High-side current-limit comparator flag |
| ot_fault | input | 1 | Over-temperature flag, hysteresis already applied |
| sw_off | output | 1 | Force both power switches off |
| ss_dump | output | 1 | Discharge the soft-start node |
| ss_restart | output | 1 | One-clock request to begin a new soft-start |

## Verification
A wrong internal state shows at the ports in one of two ways. A bad event or clean count moves the trip point: the block trips one cycle early or late in a burst of limit hits, or it fails to forgive after three clean pulses. Either shows at the clock that samples the eighth hit, or when a hit would have been the eighth. A wrong hiccup timer shows as `sw_off` releasing before or after the 1024th tick, and that is exact to the clock. A stale off history shows as a missing, doubled or mistimed `ss_restart` pulse on the clock after the release.

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int EVT_W        = 3,
  parameter int CLEAN_N      = 3,
  parameter int HICCUP_TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_tick,
  input  logic hs_start,
  input  logic ilim_hit,
  input  logic ot_fault,
  output logic sw_off,
  output logic ss_dump,
  output logic ss_restart
);
  localparam int CLN_W = $clog2(CLEAN_N + 1);
  localparam int TMR_W = $clog2(HICCUP_TICKS);

  logic [EVT_W-1:0] evt_cnt;
  logic [CLN_W-1:0] clean_cnt;
  logic [TMR_W-1:0] hic_tmr;
  logic             hic, seen, hit, off_q, restart_q;

  wire off_now   = !en | ot_fault | hic;
  wire ev        = ilim_hit & !hit & !off_now;
  wire trip      = ev & (evt_cnt == {EVT_W{1'b1}});
  wire clean_end = cyc_tick & seen & !hit & !ev;
  wire hic_last  = hic_tmr == TMR_W'(HICCUP_TICKS - 1);

  assign sw_off     = off_now;
  assign ss_dump    = off_now;
  assign ss_restart = restart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= 1'b1;
      restart_q <= 1'b0;
      hic       <= 1'b0;
      hic_tmr   <= '0;
    end else begin
      off_q     <= off_now;
      restart_q <= off_q & ~off_now;
      if (!en) begin
        hic     <= 1'b0;
        hic_tmr <= '0;
      end else if (hic) begin
        if (cyc_tick) begin
          if (hic_last) begin
            hic     <= 1'b0;
            hic_tmr <= '0;
          end else begin
            hic_tmr <= hic_tmr + 1'b1;
          end
        end
      end else if (trip) begin
        hic     <= 1'b1;
        hic_tmr <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt   <= '0;
      clean_cnt <= '0;
      seen      <= 1'b0;
      hit       <= 1'b0;
    end else if (off_now | trip) begin
      evt_cnt   <= '0;
      clean_cnt <= '0;
      seen      <= 1'b0;
      hit       <= 1'b0;
    end else begin
      if (cyc_tick) begin
        seen <= hs_start;
        hit  <= 1'b0;
      end else begin
        if (hs_start) seen <= 1'b1;
        if (ilim_hit) hit  <= 1'b1;
      end
      if (ev) begin
        evt_cnt   <= evt_cnt + 1'b1;
        clean_cnt <= '0;
      end else if (clean_end) begin
        if (clean_cnt == CLN_W'(CLEAN_N - 1)) begin
          clean_cnt <= '0;
          evt_cnt   <= '0;
        end else begin
          clean_cnt <= clean_cnt + 1'b1;
        end
      end
    end
  end
endmodule

module ocp_hiccup_chk #(
  parameter int EVT_W        = 3,
  parameter int CLEAN_N      = 3,
  parameter int HICCUP_TICKS = 1024
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              en,
  input logic                              ot_fault,
  input logic                              cyc_tick,
  input logic                              sw_off,
  input logic                              ss_restart,
  input logic                              hic,
  input logic [$clog2(HICCUP_TICKS)-1:0]   hic_tmr,
  input logic [EVT_W-1:0]                  evt_cnt,
  input logic [$clog2(CLEAN_N + 1)-1:0]    clean_cnt
);
  localparam int CLN_W = $clog2(CLEAN_N + 1);

  assert_restart_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);
  assert_restart_when_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> !sw_off);
  assert_trip_at_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hic) |-> $past(evt_cnt) == {EVT_W{1'b1}});
  assert_off_in_hiccup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hic |-> sw_off);
  assert_timer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hic && en && !cyc_tick) |=> $stable(hic_tmr));
  assert_clean_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clean_cnt < CLN_W'(CLEAN_N));
  assert_thermal_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ot_fault |=> (evt_cnt == '0 && clean_cnt == '0));
  assert_enable_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hic && hic_tmr == '0 && evt_cnt == '0));
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(
  .EVT_W(EVT_W), .CLEAN_N(CLEAN_N), .HICCUP_TICKS(HICCUP_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ot_fault(ot_fault), .cyc_tick(cyc_tick),
  .sw_off(sw_off), .ss_restart(ss_restart), .hic(hic), .hic_tmr(hic_tmr),
  .evt_cnt(evt_cnt), .clean_cnt(clean_cnt)
);

// File: tb/ocp_hiccup_ctrl_bench.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cyc_tick = 1'b0, hs_start = 1'b0, ilim_hit = 1'b0, ot_fault = 1'b0;
  logic sw_off, ss_dump, ss_restart;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ocp_hiccup_ctrl u_ocp_hiccup_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_tick(cyc_tick), .hs_start(hs_start),
    .ilim_hit(ilim_hit), .ot_fault(ot_fault), .sw_off(sw_off), .ss_dump(ss_dump),
    .ss_restart(ss_restart)
  );

  task automatic check(input logic got, input logic exp, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic cyc(input bit hs, input int nl);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cyc_tick = (k == 0);
      hs_start = hs && (k == 1);
      ilim_hit = (k == 3 && nl >= 1) || (k == 5 && nl >= 2);
    end
  endtask

  task automatic hits(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1);
  endtask

  task automatic cleans(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 0);
  endtask

  task automatic clear_all();
    @(negedge clk); en = 1'b0;
    @(negedge clk); @(negedge clk); en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check(sw_off, 1'b1, "R1 sw_off in reset state");
    check(ss_dump, 1'b1, "R1 ss_dump in reset state");
    check(ss_restart, 1'b0, "R1 restart idle after reset");
    en = 1'b1;
    #1 check(sw_off, 1'b0, "R1 sw_off drops with en");
    repeat (3) @(negedge clk);
  endtask

  task automatic t_trip();
    clear_all();
    hits(7);
    check(sw_off, 1'b0, "R3 seven events do not trip");
    hits(1);
    check(sw_off, 1'b1, "R3 eighth event trips sw_off");
    check(ss_dump, 1'b1, "R3 eighth event trips ss_dump");
  endtask

  task automatic t_double();
    clear_all();
    for (int i = 0; i < 4; i++) cyc(1'b1, 2);
    hits(3);
    check(sw_off, 1'b0, "R2 second limit pulse in a cycle not counted");
    hits(1);
    check(sw_off, 1'b1, "R2 trip at eighth counted event");
  endtask

  task automatic t_forgive();
    clear_all();
    hits(7);
    cleans(3);
    hits(7);
    check(sw_off, 1'b0, "R4 three clean pulses cleared counter");
    hits(1);
    check(sw_off, 1'b1, "R4 trip after eight fresh events");
  endtask

  task automatic t_partial();
    clear_all();
    hits(5); cleans(2); hits(1); cleans(2); hits(1);
    check(sw_off, 1'b0, "R5 seven events across short clean runs");
    hits(1);
    check(sw_off, 1'b1, "R5 short clean runs do not clear counter");
  endtask

  task automatic t_skip();
    clear_all();
    hits(7);
    for (int i = 0; i < 5; i++) cyc(1'b0, 0);
    check(sw_off, 1'b0, "R6 no trip during skipped cycles");
    hits(1);
    check(sw_off, 1'b1, "R6 skipped cycles left count intact");
  endtask

  task automatic t_hiccup();
    clear_all();
    hits(8);
    for (int i = 0; i < 1023; i++) begin
      @(negedge clk); cyc_tick = 1'b1; ilim_hit = (i % 3 == 0);
      @(negedge clk); cyc_tick = 1'b0; ilim_hit = 1'b0;
    end
    check(sw_off, 1'b1, "R7 still off after 1023 ticks");
    @(negedge clk); cyc_tick = 1'b1;
    @(negedge clk); cyc_tick = 1'b0;
    check(sw_off, 1'b0, "R7 released at 1024th tick");
    check(ss_restart, 1'b0, "R8 restart not yet high");
    @(negedge clk);
    check(ss_restart, 1'b1, "R8 restart one clock after release");
    @(negedge clk);
    check(ss_restart, 1'b0, "R8 restart one clock wide");
    hits(7);
    check(sw_off, 1'b0, "R7 counters start from zero after hiccup");
  endtask

  task automatic t_thermal();
    clear_all();
    hits(7);
    @(negedge clk); ot_fault = 1'b1;
    @(negedge clk);
    check(sw_off, 1'b1, "R9 thermal forces off");
    check(ss_dump, 1'b1, "R9 thermal dumps soft-start");
    ot_fault = 1'b0;
    @(negedge clk);
    check(ss_restart, 1'b1, "R9 restart after thermal release");
    @(negedge clk);
    check(ss_restart, 1'b0, "R8 restart single after thermal");
    hits(1);
    check(sw_off, 1'b0, "R9 thermal cleared event count");
  endtask

  task automatic t_enable();
    clear_all();
    hits(7);
    clear_all();
    hits(1);
    check(sw_off, 1'b0, "R10 enable low cleared event count");
    clear_all();
    hits(8);
    check(sw_off, 1'b1, "R10 trip before enable drop");
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check(sw_off, 1'b1, "R10 off while disabled");
    en = 1'b1;
    @(negedge clk);
    check(sw_off, 1'b0, "R10 enable drop ended hiccup");
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_trip();
    t_double();
    t_forgive();
    t_partial();
    t_skip();
    t_hiccup();
    t_thermal();
    t_enable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule